// File: doc/BRIEF.md
# Command Fetch Sequencer with One-Level Subroutine Call

This block walks the program pointer of a command engine. The host writes a start byte address, an end byte address and then sets the run bit. The sequencer then reads 64-bit instruction words in order from a word-addressed memory. Each word other than a call is handed to an external decoder over a valid/ready port. When the pointer reaches the end address, the run finishes and the busy flag drops. The end address is expected to sit on a 64-byte line, with unused slots padded by zero (no-op) words.

A call word is consumed by the sequencer and never reaches the decoder. Its top byte is 0x0C, and it carries two pointers counted in 64-byte lines. The sequencer runs the subroutine those pointers bound. It then resumes the caller at the first word of the line after the call, so the rest of the caller's line is skipped. Only one level of call exists. A call from inside a subroutine, or a call placed in one of the last two 8-byte slots of its line, raises a call-error status bit.

A small register set holds control, the two pointers, a readback of the pointer being fetched, a sticky status register and its enables. Status bits are cleared by writing ones. The irq output is raised while any enabled status bit is set.

Top module: `cmd_fetch_seq`

## Requirements
- R1: After reset, busy (control bit 31) reads 0, ins_valid, mem_rd and irq are 0, and status (register 4) reads 0.
- R2: Writing control (register 0) with bit 0 set and bit 1 clear while idle starts a run at the head (register 1). The run delivers consecutive words in address order on ins_data, one per ins_valid/ins_ready handshake. While ins_ready is low, ins_valid and ins_data hold.
- R3: Busy clears when the fetch pointer equals the tail (register 2), without reading that word. When head equals tail, the run delivers no word.
- R4: A word with bits 63:56 equal to 0x0C is a call and is never delivered. Bits 51:26 hold the subroutine start and bits 25:0 hold the subroutine end, both in 64-byte lines. The words of that range are delivered next.
- R5: When the subroutine reaches its end, fetching resumes at the first word of the line after the one that held the call.
- R6: A call in slot 6 or 7 of its line (word address bits 2:0) sets status bit 4, and the call is then carried out normally.
- R7: A call met inside a subroutine sets status bit 4, is skipped, and fetching continues with the next word.
- R8: Writing control with bit 1 set stops the run at once: from the next cycle ins_valid is 0 and busy reads 0.
- R9: Status bits 0 to 3 are set by pulses on evt_in bits 0 to 3 (program, fetch fault, response timeout, poll error). Writing a 1 to a status bit clears it unless that bit is being set in the same cycle. irq is high exactly while a status bit and its enable (register 5) are both 1.
- R10: Register 3 reads the byte address of the instruction word currently being fetched or presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 3 | Register index |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data for host_addr |
| evt_in | input | 4 | Status event pulses from the engine |
| irq | output | 1 | Any enabled status bit set |
| mem_rd | output | 1 | Instruction memory read request |
| mem_addr | output | ADDR_W-3 | Instruction word address |
| mem_rdata | input | 64 | Read data, one cycle after mem_rd |
| ins_valid | output | 1 | Instruction available to decoder |
| ins_data | output | 64 | Instruction word |
| ins_ready | input | 1 | Decoder accepts the instruction |

## Verification
The assertions assume memory returns data exactly one cycle after a read request. They also assume the host does not rewrite head or tail during a run. The bench's memory model always answers on the following edge, and the bench programs the pointers only while busy reads 0. The call pointers in every program lie inside the modelled memory, and every tail is line-aligned. Handshake stalls on ins_ready come from a fixed repeating pattern.

// File: rtl/cmd_fetch_pkg.sv
package cmd_fetch_pkg;
  localparam logic [7:0] OPC_CALL = 8'h0C;
  localparam int NUM_STS  = 5;
  localparam int STS_CALL = 4;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_HEAD = 3'd1;
  localparam logic [2:0] RA_TAIL = 3'd2;
  localparam logic [2:0] RA_CUR  = 3'd3;
  localparam logic [2:0] RA_STS  = 3'd4;
  localparam logic [2:0] RA_IEN  = 3'd5;

  typedef enum logic [1:0] {FS_IDLE, FS_ISSUE, FS_WAIT, FS_OUT} fetch_state_e;
endpackage

// File: rtl/cmd_fetch_ctl.sv
module cmd_fetch_ctl
  import cmd_fetch_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              halt,
  input  logic [ADDR_W-4:0] head_word,
  input  logic [ADDR_W-4:0] tail_word,
  output logic              busy,
  output logic [ADDR_W-4:0] cur_word,
  output logic              call_err,
  output logic              mem_rd,
  output logic [ADDR_W-4:0] mem_addr,
  input  logic [63:0]       mem_rdata,
  output logic              ins_valid,
  output logic [63:0]       ins_data,
  input  logic              ins_ready
);
  localparam int PW  = ADDR_W - 3;
  localparam int CLW = PW - 3;

  fetch_state_e   st_q, st_n;
  logic [PW-1:0]  pc_q, pc_n, ret_q, ret_n, sub_end_q, sub_end_n;
  logic           in_sub_q, in_sub_n;
  logic [63:0]    ins_q;
  logic           ins_load;
  logic [PW-1:0]  end_w, call_head, call_tail;
  logic           is_call;
  logic [63:0]    unused_rdata;

  assign end_w     = in_sub_q ? sub_end_q : tail_word;
  assign is_call   = (mem_rdata[63:56] == OPC_CALL);
  assign call_head = {mem_rdata[26 +: CLW], 3'b000};
  assign call_tail = {mem_rdata[0 +: CLW], 3'b000};
  assign unused_rdata = mem_rdata;

  always_comb begin
    st_n      = st_q;
    pc_n      = pc_q;
    ret_n     = ret_q;
    sub_end_n = sub_end_q;
    in_sub_n  = in_sub_q;
    mem_rd    = 1'b0;
    ins_load  = 1'b0;
    call_err  = 1'b0;
    case (st_q)
      FS_IDLE: if (start) begin
        pc_n     = head_word;
        in_sub_n = 1'b0;
        st_n     = FS_ISSUE;
      end
      FS_ISSUE: begin
        if (pc_q == end_w) begin
          if (in_sub_q) begin
            pc_n     = ret_q;
            in_sub_n = 1'b0;
          end else begin
            st_n = FS_IDLE;
          end
        end else begin
          mem_rd = 1'b1;
          st_n   = FS_WAIT;
        end
      end
      FS_WAIT: begin
        if (is_call) begin
          st_n = FS_ISSUE;
          if (in_sub_q) begin
            call_err = !halt;
            pc_n     = pc_q + 1'b1;
          end else begin
            call_err  = !halt && (pc_q[2:0] >= 3'd6);
            ret_n     = {pc_q[PW-1:3] + 1'b1, 3'b000};
            pc_n      = call_head;
            sub_end_n = call_tail;
            in_sub_n  = 1'b1;
          end
        end else begin
          ins_load = 1'b1;
          st_n     = FS_OUT;
        end
      end
      FS_OUT: if (ins_ready) begin
        pc_n = pc_q + 1'b1;
        st_n = FS_ISSUE;
      end
      default: st_n = FS_IDLE;
    endcase
    if (halt) begin
      st_n     = FS_IDLE;
      in_sub_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= FS_IDLE;
      pc_q      <= '0;
      ret_q     <= '0;
      sub_end_q <= '0;
      in_sub_q  <= 1'b0;
      ins_q     <= '0;
    end else begin
      st_q      <= st_n;
      pc_q      <= pc_n;
      ret_q     <= ret_n;
      sub_end_q <= sub_end_n;
      in_sub_q  <= in_sub_n;
      if (ins_load) ins_q <= mem_rdata;
    end
  end

  assign busy      = (st_q != FS_IDLE);
  assign ins_valid = (st_q == FS_OUT);
  assign ins_data  = ins_q;
  assign mem_addr  = pc_q;
  assign cur_word  = pc_q;

  assert_hold_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !ins_ready && !halt) |=> (ins_valid && $stable(ins_data)));
  assert_idle_no_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_rd);
  assert_call_hidden_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |-> (ins_data[63:56] != OPC_CALL));
  assert_return_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(in_sub_q) && busy) |-> (pc_q[2:0] == 3'b000));
  assert_halt_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (!busy && !ins_valid));
endmodule

// File: rtl/cmd_fetch_regs.sv
module cmd_fetch_regs
  import cmd_fetch_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [2:0]        host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  input  logic [3:0]        evt_in,
  input  logic              busy,
  input  logic [ADDR_W-4:0] cur_word,
  input  logic              call_err,
  output logic              start,
  output logic              halt,
  output logic [ADDR_W-4:0] head_word,
  output logic [ADDR_W-4:0] tail_word,
  output logic              irq
);
  localparam int PADW = 32 - ADDR_W;

  logic               en_q, en_n;
  logic [ADDR_W-1:0]  head_q, head_n, tail_q, tail_n;
  logic [NUM_STS-1:0] sts_q, sts_n, ien_q, ien_n, set_vec, clr_vec;
  logic               wr_ctrl;
  logic [31:0]        unused_wdata;

  assign unused_wdata = host_wdata;
  assign wr_ctrl = host_we && (host_addr == RA_CTRL);
  assign halt    = wr_ctrl && host_wdata[1];
  assign start   = wr_ctrl && host_wdata[0] && !host_wdata[1] && !busy;
  assign set_vec = {call_err, evt_in};
  assign clr_vec = (host_we && host_addr == RA_STS) ? host_wdata[NUM_STS-1:0] : '0;

  always_comb begin
    en_n   = wr_ctrl ? host_wdata[0] : en_q;
    head_n = (host_we && host_addr == RA_HEAD) ? host_wdata[ADDR_W-1:0] : head_q;
    tail_n = (host_we && host_addr == RA_TAIL) ? host_wdata[ADDR_W-1:0] : tail_q;
    ien_n  = (host_we && host_addr == RA_IEN) ? host_wdata[NUM_STS-1:0] : ien_q;
    sts_n  = (sts_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      head_q <= '0;
      tail_q <= '0;
      ien_q  <= '0;
      sts_q  <= '0;
    end else begin
      en_q   <= en_n;
      head_q <= head_n;
      tail_q <= tail_n;
      ien_q  <= ien_n;
      sts_q  <= sts_n;
    end
  end

  assign head_word = head_q[ADDR_W-1:3];
  assign tail_word = tail_q[ADDR_W-1:3];
  assign irq       = |(sts_q & ien_q);

  always_comb begin
    case (host_addr)
      RA_CTRL: host_rdata = {busy, 30'd0, en_q};
      RA_HEAD: host_rdata = {{PADW{1'b0}}, head_q};
      RA_TAIL: host_rdata = {{PADW{1'b0}}, tail_q};
      RA_CUR:  host_rdata = {{PADW{1'b0}}, cur_word, 3'b000};
      RA_STS:  host_rdata = {{(32-NUM_STS){1'b0}}, sts_q};
      RA_IEN:  host_rdata = {{(32-NUM_STS){1'b0}}, ien_q};
      default: host_rdata = '0;
    endcase
  end

  assert_w1c_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr == RA_STS) |=>
      ((sts_q & $past(host_wdata[NUM_STS-1:0]) & ~$past(set_vec)) == '0));
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!(host_we && host_addr == RA_STS)) |=> ((sts_q & $past(sts_q)) == $past(sts_q)));
endmodule

// File: rtl/cmd_fetch_seq.sv
module cmd_fetch_seq
  import cmd_fetch_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [2:0]        host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  input  logic [3:0]        evt_in,
  output logic              irq,
  output logic              mem_rd,
  output logic [ADDR_W-4:0] mem_addr,
  input  logic [63:0]       mem_rdata,
  output logic              ins_valid,
  output logic [63:0]       ins_data,
  input  logic              ins_ready
);
  logic              start, halt, busy, call_err;
  logic [ADDR_W-4:0] head_word, tail_word, cur_word;

  cmd_fetch_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .evt_in(evt_in), .busy(busy), .cur_word(cur_word), .call_err(call_err),
    .start(start), .halt(halt), .head_word(head_word), .tail_word(tail_word),
    .irq(irq)
  );

  cmd_fetch_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .start(start), .halt(halt), .head_word(head_word), .tail_word(tail_word),
    .busy(busy), .cur_word(cur_word), .call_err(call_err),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .ins_valid(ins_valid), .ins_data(ins_data), .ins_ready(ins_ready)
  );
endmodule

// File: tb/tb_cmd_fetch_seq.sv
`timescale 1ns/1ps
module tb_cmd_fetch_seq;
  localparam int ADDR_W = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic [3:0]  evt_in = '0;
  logic        irq, mem_rd, ins_valid;
  logic [ADDR_W-4:0] mem_addr;
  logic [63:0] mem_rdata = '0;
  logic [63:0] ins_data;
  logic        ins_ready = 1'b1;

  logic [63:0] mem [0:255];
  logic [63:0] exp_q[$];
  string       exp_req = "R2";
  int          n_chk = 0, n_bad = 0, cyc = 0;
  bit          stall_en = 1'b0, ready_lo = 1'b0, done = 1'b0;

  always #2.5 clk = ~clk;

  cmd_fetch_seq #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .evt_in(evt_in), .irq(irq),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .ins_valid(ins_valid), .ins_data(ins_data), .ins_ready(ins_ready)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
  end

  initial forever begin
    @(posedge clk); #1;
    ins_ready = ready_lo ? 1'b0 : (stall_en ? ((cyc % 3) != 0) : 1'b1);
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && ins_valid && ins_ready) begin
      if (exp_q.size() == 0) check(exp_req, ins_data, 64'hDEAD_0000_0000_0000);
      else check(exp_req, ins_data, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk); #1;
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    host_addr = a;
    @(negedge clk);
    d = host_rdata;
  endtask

  function automatic logic [63:0] dword(input int i);
    return {8'hA5, 24'h0, 32'(i)};
  endfunction

  function automatic logic [63:0] call_w(input int hl, input int tl);
    return {8'h0C, 4'h0, 26'(hl), 26'(tl)};
  endfunction

  task automatic run(input string req, input int head_b, input int tail_b);
    logic [31:0] r;
    exp_req = req;
    wr(3'd1, 32'(head_b));
    wr(3'd2, 32'(tail_b));
    wr(3'd0, 32'h1);
    for (int k = 0; k < 2000; k++) begin
      rd(3'd0, r);
      if (!r[31]) break;
    end
    check({req, " busy cleared"}, 64'(r[31]), 64'd0);
    check({req, " all words seen"}, 64'(exp_q.size()), 64'd0);
    exp_q.delete();
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    for (int i = 0; i < 256; i++) mem[i] = 64'd0;
    for (int i = 0; i < 16; i++) mem[i] = dword(i);
    mem[32] = dword(32); mem[33] = call_w(8, 9);
    for (int i = 40; i < 48; i++) mem[i] = dword(i);
    for (int i = 64; i < 72; i++) mem[i] = dword(i);
    for (int i = 80; i < 86; i++) mem[i] = dword(i);
    mem[86] = call_w(8, 9);
    for (int i = 88; i < 96; i++) mem[i] = dword(i);
    for (int i = 104; i < 112; i++) mem[i] = dword(i);
    mem[105] = call_w(8, 9);
    mem[120] = call_w(13, 14);

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 ins_valid", 64'(ins_valid), 0);
    check("R1 mem_rd", 64'(mem_rd), 0);
    check("R1 irq", 64'(irq), 0);
    rd(3'd0, r); check("R1 ctrl", 64'(r), 0);
    rd(3'd4, r); check("R1 status", 64'(r), 0);

    // R2 straight-line program with stalls
    stall_en = 1'b1;
    for (int i = 0; i < 16; i++) exp_q.push_back(dword(i));
    run("R2", 0, 128);

    // R3 empty program
    run("R3", 64, 64);

    // R4 / R5 call from slot 1, then resume at next line
    exp_q.push_back(dword(32));
    for (int i = 64; i < 72; i++) exp_q.push_back(dword(i));
    for (int i = 40; i < 48; i++) exp_q.push_back(dword(i));
    run("R4_R5", 256, 384);
    rd(3'd4, r); check("R6 no error for slot 1 call", 64'(r[4]), 0);

    // R6 call in slot 6
    for (int i = 80; i < 86; i++) exp_q.push_back(dword(i));
    for (int i = 64; i < 72; i++) exp_q.push_back(dword(i));
    for (int i = 88; i < 96; i++) exp_q.push_back(dword(i));
    run("R6", 640, 768);
    rd(3'd4, r); check("R6 call error set", 64'(r), 64'h10);
    wr(3'd4, 32'h10);
    rd(3'd4, r); check("R9 call error cleared", 64'(r), 0);

    // R7 nested call skipped
    exp_q.push_back(dword(104));
    for (int i = 106; i < 112; i++) exp_q.push_back(dword(i));
    run("R7", 960, 1024);
    rd(3'd4, r); check("R7 call error set", 64'(r), 64'h10);
    wr(3'd4, 32'h10);

    // R10 / R8 current pointer and halt
    stall_en = 1'b0; ready_lo = 1'b1;
    wr(3'd1, 32'd16); wr(3'd2, 32'd128); wr(3'd0, 32'h1);
    for (int k = 0; k < 50 && !ins_valid; k++) @(negedge clk);
    check("R2 valid held while stalled", 64'(ins_valid), 1);
    check("R2 first word from head", ins_data, dword(2));
    rd(3'd3, r); check("R10 current head", 64'(r), 64'd16);
    wr(3'd0, 32'h2);
    check("R8 ins_valid dropped", 64'(ins_valid), 0);
    rd(3'd0, r); check("R8 busy cleared", 64'(r[31]), 0);
    ready_lo = 1'b0;

    // R9 events, enables, irq
    @(posedge clk); #1 evt_in = 4'b0010;
    @(posedge clk); #1 evt_in = 4'b0000;
    rd(3'd4, r); check("R9 fault status", 64'(r), 64'h2);
    check("R9 irq masked", 64'(irq), 0);
    wr(3'd5, 32'h2);
    @(negedge clk); check("R9 irq enabled", 64'(irq), 1);
    wr(3'd4, 32'h1);
    rd(3'd4, r); check("R9 clear of other bit keeps fault", 64'(r), 64'h2);
    wr(3'd4, 32'h2);
    rd(3'd4, r); check("R9 fault cleared", 64'(r), 0);
    check("R9 irq low", 64'(irq), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule